// File: doc/BRIEF.md
# Debug show-cycle bus mirror

This block copies internal bus transfers onto an external debug bus, so that accesses which never leave the chip can still be watched on a logic analyser. Each internal transfer supplies an address, a function code, a size, a direction and its data, followed later by a completion pulse. The block presents the transfer on the external pins through a four-phase sequencer: ADDR, STROBE, WAIT and DATA. The sequencer advances one phase on each clock where the half-clock enable `phase_en` is high, so every enabled clock is half of the external bus clock.

A mirrored cycle never asserts the address strobe. The data strobe takes over address-strobe timing: it asserts one phase after the address is shown and stays asserted through any wait states. The data drivers open only once the internal transfer has completed. They stay open through the following ADDR phase while the address pins already move to the next transfer. After reset, mirroring is off. In that mode the address and control pins still track internal traffic, both strobes stay negated and the data bus stays released. Software turns mirroring on by writing a nonzero value to the enable field.

Top module: `show_mirror`

## Requirements
- R1: After reset, mirroring is disabled, the sequencer is in ADDR, `ext_ds_n` and `ext_as_n` are high and `ext_doe` is low.
- R2: When `cfg_we` is high, the enable field takes `cfg_wdata` at the clock edge. Any nonzero value enables mirroring and zero disables it. The new setting affects the strobe and drive outputs from the next cycle onward.
- R3: While mirroring is disabled, the sequencer still runs and the address, function code, size and direction outputs still follow transfers, but `ext_ds_n` and `ext_as_n` stay high and `ext_doe` stays low.
- R4: In ADDR, `ext_addr`, `ext_fc`, `ext_size` and `ext_rw` show the live request fields. `ext_rw` is 1 for a read and 0 for a write. `ext_size` passes the byte-count code through unchanged (1, 2 or 3 bytes, 0 meaning four bytes).
- R5: A step in ADDR with `req_valid` high moves to STROBE. With mirroring enabled, `ext_ds_n` is low exactly in STROBE and WAIT, so it falls one phase after ADDR. `ext_as_n` is never low.
- R6: After STROBE comes at least one WAIT phase, and WAIT repeats until completion. `int_done` is recorded on any clock while in STROBE or WAIT and is ignored in ADDR and DATA. A step in WAIT leaves for DATA when completion has been recorded or `int_done` is high in that clock. With a step on every clock and `int_done` pulsed in the j-th strobe-low clock, `ext_ds_n` is low for max(2, j) clocks.
- R7: In DATA, with mirroring enabled, `ext_ds_n` is high, `ext_doe` is high and `ext_dout` equals `int_data` as sampled on the first completion clock of that transfer.
- R8: Drive continues through the ADDR phase that follows DATA, with the same data, while the address and control outputs already show the next request. `ext_doe` drops at the next step.
- R9: On clocks where `phase_en` is low, the phase state does not advance, and the latched address and control fields do not change.
- R10: From STROBE through DATA, the address and control outputs hold the values latched when ADDR was left, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the external bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | 1 | Half-clock step enable for the sequencer |
| cfg_we | input | 1 | Write strobe for the enable field |
| cfg_wdata | input | EN_W | New enable field value, nonzero enables |
| req_valid | input | 1 | Internal transfer pending |
| req_addr | input | AW | Internal transfer address |
| req_fc | input | FW | Internal function code |
| req_size | input | SW | Byte-count code |
| req_rd | input | 1 | 1 for a read, 0 for a write |
| int_data | input | DW | Internal bus data |
| int_done | input | 1 | Internal transfer completion pulse |
| ext_addr | output | AW | Mirrored address |
| ext_fc | output | FW | Mirrored function code |
| ext_size | output | SW | Mirrored size |
| ext_rw | output | 1 | Mirrored direction, 1 = read |
| ext_as_n | output | 1 | Address strobe, active low, never asserted |
| ext_ds_n | output | 1 | Data strobe, active low |
| ext_dout | output | DW | Mirrored data |
| ext_doe | output | 1 | Output enable for the data bus drivers |

## Verification
The closest collision is at the end of a transfer. The ADDR phase that holds the previous transfer's data on the bus is also the phase that shows, and can accept, the next request. The bench chains transfers back to back, so every DATA phase is followed by a live ADDR phase with a new request. It also changes the request inputs as soon as a transfer is accepted. It then judges, clock by clock against its reference model, that the drive and its data belong to the old transfer while the address pins follow the new one. A second collision comes from gapped `phase_en` patterns: completion then lands in a clock with no step. The model checks that this completion is still recorded and that the sequencer exits WAIT at the next step.

// File: rtl/smr_pkg.sv
package smr_pkg;
   typedef enum logic [1:0] {
      ST_ADDR   = 2'd0,
      ST_STROBE = 2'd1,
      ST_WAIT   = 2'd2,
      ST_DATA   = 2'd3
   } phase_t;
endpackage

// File: rtl/smr_cfg.sv
module smr_cfg #(
   parameter int EN_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [EN_W-1:0] cfg_wdata,
   output logic            en
);
   logic [EN_W-1:0] field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      field_q <= '0;
      else if (cfg_we) field_q <= cfg_wdata;
   end

   assign en = |field_q;

   // R1
   cfg_reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && !$past(en)) |-> !en);
endmodule

// File: rtl/smr_seq.sv
module smr_seq
   import smr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   step,
   input  logic   req_valid,
   input  logic   done,
   output phase_t st,
   output logic   hold,
   output logic   cap,
   output logic   accept,
   output logic   busy
);
   phase_t st_q, st_d;
   logic   done_q, hold_q, leave_wait;

   assign busy       = (st_q == ST_STROBE) || (st_q == ST_WAIT);
   assign cap        = done && busy && !done_q;
   assign accept     = step && (st_q == ST_ADDR) && req_valid;
   assign leave_wait = step && (st_q == ST_WAIT) && (done_q || done);

   always_comb begin
      st_d = st_q;
      if (step) begin
         unique case (st_q)
            ST_ADDR:   if (req_valid)  st_d = ST_STROBE;
            ST_STROBE:                 st_d = ST_WAIT;
            ST_WAIT:   if (leave_wait) st_d = ST_DATA;
            ST_DATA:                   st_d = ST_ADDR;
            default:                   st_d = ST_ADDR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_ADDR;
         done_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (leave_wait)        done_q <= 1'b0;
         else if (done && busy) done_q <= 1'b1;
         if (step)              hold_q <= (st_q == ST_DATA);
      end
   end

   assign st   = st_q;
   assign hold = hold_q;

   // R6
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && st_q == ST_WAIT && !done_q && !done) |=> st_q == ST_WAIT);
   // R9
   no_step_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(st_q));
endmodule

// File: rtl/smr_drv.sv
module smr_drv
   import smr_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int FW        = 3,
   parameter int SW        = 2,
   parameter bit LIVE_DATA = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          en,
   input  phase_t        st,
   input  logic          hold,
   input  logic          busy,
   input  logic          accept,
   input  logic          cap,
   input  logic [AW-1:0] req_addr,
   input  logic [FW-1:0] req_fc,
   input  logic [SW-1:0] req_size,
   input  logic          req_rd,
   input  logic [DW-1:0] int_data,
   output logic [AW-1:0] ext_addr,
   output logic [FW-1:0] ext_fc,
   output logic [SW-1:0] ext_size,
   output logic          ext_rw,
   output logic          ext_as_n,
   output logic          ext_ds_n,
   output logic [DW-1:0] ext_dout,
   output logic          ext_doe
);
   localparam int CTL_W = AW + FW + SW + 1;

   logic [CTL_W-1:0] ctl_live, ctl_q, ctl_out;
   logic             in_addr;

   assign in_addr  = (st == ST_ADDR);
   assign ctl_live = {req_addr, req_fc, req_size, req_rd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (accept) ctl_q <= ctl_live;
   end

   assign ctl_out = in_addr ? ctl_live : ctl_q;
   assign {ext_addr, ext_fc, ext_size, ext_rw} = ctl_out;

   assign ext_as_n = 1'b1;
   assign ext_ds_n = ~(en && busy);
   assign ext_doe  = en && ((st == ST_DATA) || (in_addr && hold));

   generate
      if (LIVE_DATA) begin : g_live
         assign ext_dout = int_data;
      end else begin : g_capt
         logic [DW-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   data_q <= '0;
            else if (cap) data_q <= int_data;
         end
         assign ext_dout = data_q;

         // R7
         drive_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_doe && $past(ext_doe)) |-> $stable(ext_dout));
      end
   endgenerate

   // R10
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_ADDR && $past(st) != ST_ADDR) |-> $stable(ctl_out));
   // R8
   drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && in_addr && hold) |=> !ext_doe);
endmodule

// File: rtl/show_mirror.sv
module show_mirror
   import smr_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int FW        = 3,
   parameter int SW        = 2,
   parameter int EN_W      = 2,
   parameter bit LIVE_DATA = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            phase_en,
   input  logic            cfg_we,
   input  logic [EN_W-1:0] cfg_wdata,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   input  logic [FW-1:0]   req_fc,
   input  logic [SW-1:0]   req_size,
   input  logic            req_rd,
   input  logic [DW-1:0]   int_data,
   input  logic            int_done,
   output logic [AW-1:0]   ext_addr,
   output logic [FW-1:0]   ext_fc,
   output logic [SW-1:0]   ext_size,
   output logic            ext_rw,
   output logic            ext_as_n,
   output logic            ext_ds_n,
   output logic [DW-1:0]   ext_dout,
   output logic            ext_doe
);
   generate
      if (AW < 1 || DW < 1 || FW < 1 || SW < 1) begin : g_bad_width
         $error("show_mirror: all bus widths must be at least 1");
      end
      if (EN_W < 1) begin : g_bad_en
         $error("show_mirror: EN_W must be at least 1");
      end
   endgenerate

   logic   en, hold, cap, accept, busy;
   phase_t st;

   smr_cfg #(.EN_W(EN_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .en(en)
   );

   smr_seq u_seq (
      .clk(clk), .rst_n(rst_n), .step(phase_en), .req_valid(req_valid),
      .done(int_done), .st(st), .hold(hold), .cap(cap), .accept(accept),
      .busy(busy)
   );

   smr_drv #(.AW(AW), .DW(DW), .FW(FW), .SW(SW), .LIVE_DATA(LIVE_DATA)) u_drv (
      .clk(clk), .rst_n(rst_n), .step(phase_en), .en(en), .st(st), .hold(hold),
      .busy(busy), .accept(accept), .cap(cap), .req_addr(req_addr),
      .req_fc(req_fc), .req_size(req_size), .req_rd(req_rd),
      .int_data(int_data), .ext_addr(ext_addr), .ext_fc(ext_fc),
      .ext_size(ext_size), .ext_rw(ext_rw), .ext_as_n(ext_as_n),
      .ext_ds_n(ext_ds_n), .ext_dout(ext_dout), .ext_doe(ext_doe)
   );

   // R5
   ds_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ext_ds_n) && $past(en)) |-> $past(st) == ST_ADDR);
endmodule

// File: tb/sim_show_mirror.sv
module sim_show_mirror;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phase_en = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_fc = '0;
   logic [1:0]  req_size = '0;
   logic        req_rd = 1'b0;
   logic [31:0] int_data = '0;
   logic        int_done = 1'b0;
   logic [31:0] ext_addr, ext_dout;
   logic [2:0]  ext_fc;
   logic [1:0]  ext_size;
   logic        ext_rw, ext_as_n, ext_ds_n, ext_doe;

   show_mirror u0 (
      .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .req_fc(req_fc), .req_size(req_size), .req_rd(req_rd),
      .int_data(int_data), .int_done(int_done), .ext_addr(ext_addr),
      .ext_fc(ext_fc), .ext_size(ext_size), .ext_rw(ext_rw),
      .ext_as_n(ext_as_n), .ext_ds_n(ext_ds_n), .ext_dout(ext_dout),
      .ext_doe(ext_doe)
   );

   always #5 clk = ~clk;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;
   bit gappy   = 1'b0;

   // behavioural reference: phase 0..3 = ADDR, STROBE, WAIT, DATA
   int          m_ph;
   bit          m_en, m_hold, m_done;
   logic [31:0] m_addr, m_data;
   logic [2:0]  m_fc;
   logic [1:0]  m_size;
   logic        m_rw;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_en <= 0; m_hold <= 0; m_done <= 0;
         m_addr <= 0; m_data <= 0; m_fc <= 0; m_size <= 0; m_rw <= 0;
      end else begin
         bit in_busy, go;
         in_busy = (m_ph == 1) || (m_ph == 2);
         go = phase_en && (m_ph == 2) && (m_done || int_done);
         if (cfg_we) m_en <= (cfg_wdata != 0);
         if (int_done && in_busy && !m_done) m_data <= int_data;
         if (go) m_done <= 0;
         else if (int_done && in_busy) m_done <= 1;
         if (phase_en) begin
            m_hold <= (m_ph == 3);
            if (m_ph == 0 && req_valid) begin
               m_ph <= 1;
               m_addr <= req_addr; m_fc <= req_fc; m_size <= req_size; m_rw <= req_rd;
            end else if (m_ph == 1) m_ph <= 2;
            else if (go) m_ph <= 3;
            else if (m_ph == 3) m_ph <= 0;
         end
      end
   end

   task automatic miss(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
   endtask

   task automatic compare();
      logic [31:0] e_addr;
      logic [2:0]  e_fc;
      logic [1:0]  e_size;
      logic        e_rw, e_ds, e_oe;
      bit          live;
      live   = (m_ph == 0);
      e_addr = live ? req_addr : m_addr;
      e_fc   = live ? req_fc   : m_fc;
      e_size = live ? req_size : m_size;
      e_rw   = live ? req_rd   : m_rw;
      e_ds   = !(m_en && (m_ph == 1 || m_ph == 2));
      e_oe   = m_en && (m_ph == 3 || (m_ph == 0 && m_hold));
      vectors++;
      if (ext_addr !== e_addr) miss(live ? "R4" : "R10", "addr", ext_addr, e_addr);
      if (ext_fc   !== e_fc)   miss(live ? "R4" : "R10", "fc", 32'(ext_fc), 32'(e_fc));
      if (ext_size !== e_size) miss(live ? "R4" : "R10", "size", 32'(ext_size), 32'(e_size));
      if (ext_rw   !== e_rw)   miss(live ? "R4" : "R10", "rw", 32'(ext_rw), 32'(e_rw));
      if (ext_ds_n !== e_ds)   miss(m_en ? "R5" : "R3", "ds_n", 32'(ext_ds_n), 32'(e_ds));
      if (ext_as_n !== 1'b1)   miss("R5", "as_n", 32'(ext_as_n), 32'd1);
      if (ext_doe  !== e_oe)   miss(m_ph == 0 ? "R8" : "R7", "doe", 32'(ext_doe), 32'(e_oe));
      if (e_oe && ext_dout !== m_data) miss(m_ph == 0 ? "R8" : "R7", "dout", ext_dout, m_data);
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
      phase_en = gappy ? 1'($urandom_range(0, 1)) : 1'b1;
      cfg_we   = 1'b0;
   endtask

   task automatic xfer(input logic [31:0] a, input logic [2:0] f, input logic [1:0] s,
                       input logic r, input logic [31:0] d, input int j, input bit cnt_chk);
      int  n, low;
      bit  seen;
      n = 0; low = 0; seen = 0;
      req_addr = a; req_fc = f; req_size = s; req_rd = r; req_valid = 1'b1;
      int_data = ~d; int_done = 1'b0;
      forever begin
         tick();
         if (ext_ds_n == 1'b0) low++;
         if (m_ph != 0) begin
            req_valid = 1'b0;
            req_addr = a ^ 32'h5A5A_0F0F; req_fc = ~f; req_size = ~s; req_rd = ~r;
         end
         if (m_ph == 1 || m_ph == 2) n++;
         int_done = (n == j) && (m_ph == 1 || m_ph == 2);
         int_data = int_done ? d : ~d;
         if (m_ph == 3) seen = 1;
         if (seen && m_ph == 0) break;
      end
      int_done = 1'b0;
      if (cnt_chk) begin
         int exp_low;
         exp_low = (j < 2) ? 2 : j;
         vectors++;
         if (low != exp_low) miss("R6", "strobe-low clocks", 32'(low), 32'(exp_low));
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired, run hung");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      vectors++;
      if (ext_ds_n !== 1'b1 || ext_as_n !== 1'b1 || ext_doe !== 1'b0)
         miss("R1", "strobes/doe in reset", {29'd0, ext_ds_n, ext_as_n, ext_doe}, 32'h6);
      rst_n = 1'b1;
      tick(); tick();

      // R3: disabled mirroring still tracks addresses
      xfer(32'h0000_1000, 3'd5, 2'd0, 1'b1, 32'hCAFE_0001, 1, 1'b0);
      xfer(32'h0000_2004, 3'd1, 2'd1, 1'b0, 32'hCAFE_0002, 3, 1'b0);
      repeat (3) tick();

      // R2: enable with a nonzero field value
      cfg_wdata = 2'b01; cfg_we = 1'b1;
      tick();
      // R6: wait count against completion delay
      for (int j = 1; j <= 5; j++)
         xfer(32'h1000_0000 + 32'(j * 16), 3'(j), 2'(j), 1'(j & 1), 32'hD000_0000 + 32'(j), j, 1'b1);
      // back-to-back R8 overlap: next request already waiting in hold ADDR
      xfer(32'h2222_0000, 3'd2, 2'd2, 1'b1, 32'h1234_5678, 2, 1'b0);
      xfer(32'h3333_0000, 3'd3, 2'd3, 1'b0, 32'h8765_4321, 4, 1'b0);
      repeat (2) tick();

      // R9: gapped phase steps
      gappy = 1'b1;
      for (int k = 0; k < 8; k++)
         xfer(32'h4000_0000 + 32'(k), 3'(k), 2'(k), 1'(k >> 1), 32'hBEEF_0000 + 32'(k), 1 + (k % 4), 1'b0);
      repeat (10) tick();
      gappy = 1'b0;

      // R2: field value 2'b10 also enables, then zero disables mid-sequence
      cfg_wdata = 2'b10; cfg_we = 1'b1;
      tick();
      xfer(32'h5555_0000, 3'd6, 2'd1, 1'b1, 32'hA5A5_A5A5, 3, 1'b1);
      cfg_wdata = 2'b00; cfg_we = 1'b1;
      tick();
      xfer(32'h6666_0000, 3'd7, 2'd2, 1'b1, 32'h0F0F_0F0F, 2, 1'b0);
      // R3: disabled again, nothing driven
      vectors++;
      if (ext_ds_n !== 1'b1 || ext_doe !== 1'b0)
         miss("R3", "strobe/doe after disable", {30'd0, ext_ds_n, ext_doe}, 32'h2);
      repeat (4) tick();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule